// File: doc/BRIEF.md
# Stepped Stereo Gain Ramp with Soft Mute

The block scales a stereo pair of signed 24-bit samples by a per-channel gain once per frame. Each channel takes a 6-bit level code, and the applied gain never jumps to it. Instead, the applied level walks toward the requested level in steps of 1 dB, one step per fixed number of frames. A per-channel mute bit makes the requested level zero, which is silence, so muting and unmuting are both gradual ramps. The right channel can also be inverted in polarity at the output.

In zero-cross mode a step is armed on the frame interval but is only taken when the signal of that channel crosses zero. A frame counter forces the step through if no crossing arrives in time. Only one channel holds an armed step at a time, and the two channels take turns, so crossings on one channel never release a step on the other. A typical use sits between a sample source and an output stage: software writes level codes and mute bits, and the block removes zipper noise and clicks from those changes.

Top module: `soft_ramp_atten`

## Requirements
- R1: After reset, outValid, outL and outR are 0 and both applied levels are 63 (unity gain), so the first frame after reset leaves samples unchanged.
- R2: The gain for level code c is G(c), with G(63) = 2^23 and G(c-1) = (G(c)*956973408 + 2^29) >> 30 for c from 63 down to 2 (a -1 dB step in Q1.23). G(0) = 0, so level 0 gives an exact zero output.
- R3: Each output equals the input sample times G(level), plus 2^22, arithmetically shifted right by 23, saturated to the range -2^23 .. 2^23-1. The level used is the applied level held before that frame's strobe.
- R4: With zero-cross mode off, on every 8th strobe after reset (strobes 8, 16, ...) each channel whose applied level differs from its requested level moves by exactly one code toward it. Levels never change on any other cycle.
- R5: While a channel's mute bit is 1, its requested level is 0 and the channel ramps down one step per interval. When the bit is cleared, the channel ramps back up to its level code in the same way.
- R6: With zero-cross mode on, an interval strobe arms a step for one channel and the step is not taken at once. The step is taken on a later strobe where that channel's input sign bit differs from its previous sample, or where the input is exactly 0.
- R7: An armed step with no crossing is taken on the 512th strobe after the arming strobe.
- R8: In zero-cross mode the arming goes to the channel whose turn it is (left first after reset). If that channel is already at its requested level, the step goes to the other channel. After a step is taken the turn passes to the other channel, and interval strobes that arrive while a step is armed are ignored.
- R9: With invRight at 1 the right output is the negated scaled value, and -2^23 becomes 2^23-1. The left output is not affected.
- R10: outValid is 1 for exactly the cycle after each frameStrobe. outL and outR change only in that cycle and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameStrobe | input | 1 | One-cycle pulse, one per sample pair |
| inL | input | 24 | Left input sample, two's complement |
| inR | input | 24 | Right input sample, two's complement |
| levelL | input | 6 | Left requested level code, 63 = 0 dB |
| levelR | input | 6 | Right requested level code, 63 = 0 dB |
| muteL | input | 1 | Ramp left channel to silence |
| muteR | input | 1 | Ramp right channel to silence |
| zcEn | input | 1 | Take level steps only at zero crossings |
| invRight | input | 1 | Invert right output polarity |
| outL | output | 24 | Left scaled sample |
| outR | output | 24 | Right scaled sample |
| outValid | output | 1 | Outputs updated this cycle |

## Verification
Any error in an applied level shows up as a wrong output value on the very next strobe, because every frame multiplies by the level held at that moment. Sample values near full scale expose a one-code error as a change of about 11 percent. A step counter that is off by one shows up one interval early or late, and the last step of a ramp moves from one frame to another. In zero-cross mode, a wrong turn or a wrong timeout count changes which channel's output moves and on which frame, so up to 512 frames can pass before the output disagrees.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int unsigned LEVEL_W   = 6;
  localparam int unsigned GAIN_W    = 24;
  localparam int unsigned GAIN_FRAC = 23;
  localparam int unsigned LEVELS    = 2 ** LEVEL_W;
  // 10^(-1/20) scaled by 2^30
  localparam longint unsigned STEP_MUL = 64'd956973408;

  typedef logic [LEVEL_W-1:0] level_t;
  typedef logic [LEVELS-1:0][GAIN_W-1:0] gain_tab_t;

  typedef struct packed {
    logic   load;
    level_t levelL;
    level_t levelR;
  } dp_ctrl_t;

  function automatic gain_tab_t buildGainTab();
    gain_tab_t tab;
    longint unsigned g;
    g = 64'd1 << GAIN_FRAC;
    for (int c = LEVELS - 1; c >= 1; c--) begin
      tab[c] = GAIN_W'(g);
      g = (g * STEP_MUL + (64'd1 << 29)) >> 30;
    end
    tab[0] = '0;
    return tab;
  endfunction
endpackage

// File: rtl/atten_ctrl.sv
module atten_ctrl
  import atten_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int STEP_FRAMES = 8,
  parameter int ZC_TIMEOUT  = 512
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     frameStrobe,
  input  logic signed [DATA_W-1:0] inL,
  input  logic signed [DATA_W-1:0] inR,
  input  level_t                   levelL,
  input  level_t                   levelR,
  input  logic                     muteL,
  input  logic                     muteR,
  input  logic                     zcEn,
  output dp_ctrl_t                 dpCtrl
);
  localparam int CNT_W  = (STEP_FRAMES > 1) ? $clog2(STEP_FRAMES) : 1;
  localparam int WAIT_W = (ZC_TIMEOUT > 1) ? $clog2(ZC_TIMEOUT) : 1;
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(STEP_FRAMES - 1);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(ZC_TIMEOUT - 1);

  logic signed [DATA_W-1:0] smp [2];
  level_t                   code [2];
  logic [1:0]               mute;
  level_t                   tgt [2];
  level_t                   cur [2];
  level_t                   nxtCur [2];
  logic [1:0]               prevSign;
  logic [1:0]               zc;
  logic [1:0]               diff;
  logic [CNT_W-1:0]         frameCnt;
  logic [WAIT_W-1:0]        waitCnt, nxtWait;
  logic                     armed, nxtArmed;
  logic                     turn, nxtTurn;
  logic                     tick;

  assign smp[0]  = inL;
  assign smp[1]  = inR;
  assign code[0] = levelL;
  assign code[1] = levelR;
  assign mute    = {muteR, muteL};

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    assign tgt[ch]  = mute[ch] ? '0 : code[ch];
    assign diff[ch] = (cur[ch] != tgt[ch]);
    assign zc[ch]   = (smp[ch][DATA_W-1] != prevSign[ch]) || (smp[ch] == '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cur[ch]      <= '1;
        prevSign[ch] <= 1'b0;
      end else if (frameStrobe) begin
        cur[ch]      <= nxtCur[ch];
        prevSign[ch] <= smp[ch][DATA_W-1];
      end
    end
  end

  function automatic level_t stepToward(input level_t c, input level_t t);
    if (c < t)      return c + 1'b1;
    else if (c > t) return c - 1'b1;
    else            return c;
  endfunction

  assign tick = (frameCnt == CNT_LAST);

  always_comb begin
    nxtCur[0] = cur[0];
    nxtCur[1] = cur[1];
    nxtArmed  = armed;
    nxtTurn   = turn;
    nxtWait   = waitCnt;
    if (!zcEn) begin
      nxtArmed = 1'b0;
      nxtWait  = '0;
      if (tick) begin
        nxtCur[0] = stepToward(cur[0], tgt[0]);
        nxtCur[1] = stepToward(cur[1], tgt[1]);
      end
    end else if (armed) begin
      if (zc[turn] || (waitCnt == WAIT_LAST)) begin
        nxtCur[turn] = stepToward(cur[turn], tgt[turn]);
        nxtArmed     = 1'b0;
        nxtTurn      = ~turn;
        nxtWait      = '0;
      end else begin
        nxtWait = waitCnt + 1'b1;
      end
    end else if (tick) begin
      nxtWait = '0;
      if (diff[turn]) begin
        nxtArmed = 1'b1;
      end else if (diff[~turn]) begin
        nxtArmed = 1'b1;
        nxtTurn  = ~turn;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameCnt <= '0;
      waitCnt  <= '0;
      armed    <= 1'b0;
      turn     <= 1'b0;
    end else if (frameStrobe) begin
      frameCnt <= tick ? '0 : frameCnt + 1'b1;
      waitCnt  <= nxtWait;
      armed    <= nxtArmed;
      turn     <= nxtTurn;
    end
  end

  assign dpCtrl.load   = frameStrobe;
  assign dpCtrl.levelL = cur[0];
  assign dpCtrl.levelR = cur[1];
endmodule

// File: rtl/atten_dp.sv
module atten_dp
  import atten_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dp_ctrl_t                 dpCtrl,
  input  logic                     invRight,
  input  logic signed [DATA_W-1:0] inL,
  input  logic signed [DATA_W-1:0] inR,
  output logic signed [DATA_W-1:0] outL,
  output logic signed [DATA_W-1:0] outR,
  output logic                     outValid
);
  localparam gain_tab_t GAIN_TAB = buildGainTab();
  localparam int PROD_W = DATA_W + GAIN_W + 1;
  localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) << (GAIN_FRAC - 1);
  localparam logic signed [PROD_W-1:0] HI =
    $signed({{(PROD_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}});
  localparam logic signed [PROD_W-1:0] LO =
    $signed({{(PROD_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}});
  localparam logic signed [DATA_W-1:0] MAXV = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] MINV = {1'b1, {(DATA_W-1){1'b0}}};

  function automatic logic signed [DATA_W-1:0] scaleSat(
    input logic signed [DATA_W-1:0] s, input level_t lv);
    logic signed [PROD_W-1:0] p;
    logic signed [PROD_W-1:0] r;
    p = s * $signed({1'b0, GAIN_TAB[lv]});
    r = (p + HALF) >>> GAIN_FRAC;
    if (r > HI)      return MAXV;
    else if (r < LO) return MINV;
    else             return r[DATA_W-1:0];
  endfunction

  function automatic logic signed [DATA_W-1:0] negSat(
    input logic signed [DATA_W-1:0] v);
    logic signed [DATA_W:0] n;
    n = -$signed({v[DATA_W-1], v});
    if (n > $signed({2'b00, {(DATA_W-1){1'b1}}})) return MAXV;
    else return n[DATA_W-1:0];
  endfunction

  logic signed [DATA_W-1:0] scaledL, scaledR, finalR;

  assign scaledL = scaleSat(inL, dpCtrl.levelL);
  assign scaledR = scaleSat(inR, dpCtrl.levelR);
  assign finalR  = invRight ? negSat(scaledR) : scaledR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outL     <= '0;
      outR     <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= dpCtrl.load;
      if (dpCtrl.load) begin
        outL <= scaledL;
        outR <= finalR;
      end
    end
  end
endmodule

// File: rtl/soft_ramp_atten.sv
module soft_ramp_atten
  import atten_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int STEP_FRAMES = 8,
  parameter int ZC_TIMEOUT  = 512
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     frameStrobe,
  input  logic signed [DATA_W-1:0] inL,
  input  logic signed [DATA_W-1:0] inR,
  input  logic [LEVEL_W-1:0]       levelL,
  input  logic [LEVEL_W-1:0]       levelR,
  input  logic                     muteL,
  input  logic                     muteR,
  input  logic                     zcEn,
  input  logic                     invRight,
  output logic signed [DATA_W-1:0] outL,
  output logic signed [DATA_W-1:0] outR,
  output logic                     outValid
);
  dp_ctrl_t dpCtrl;

  atten_ctrl #(
    .DATA_W(DATA_W), .STEP_FRAMES(STEP_FRAMES), .ZC_TIMEOUT(ZC_TIMEOUT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .frameStrobe(frameStrobe),
    .inL(inL), .inR(inR), .levelL(levelL), .levelR(levelR),
    .muteL(muteL), .muteR(muteR), .zcEn(zcEn), .dpCtrl(dpCtrl)
  );

  atten_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .dpCtrl(dpCtrl), .invRight(invRight),
    .inL(inL), .inR(inR), .outL(outL), .outR(outR), .outValid(outValid)
  );
endmodule

// File: rtl/soft_ramp_atten_checker.sv
module soft_ramp_atten_checker #(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameStrobe,
  input logic              zcEn,
  input logic [5:0]        curL,
  input logic [5:0]        curR,
  input logic [DATA_W-1:0] outL,
  input logic [DATA_W-1:0] outR,
  input logic              outValid
);
  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe |=> outValid);

  p_valid_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !frameStrobe |=> !outValid);

  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !frameStrobe |=> ($stable(outL) && $stable(outR)));

  p_level_frozen_r4: assert property (@(posedge clk) disable iff (!rstN)
    !frameStrobe |=> ($stable(curL) && $stable(curR)));

  p_unit_step_left_r4: assert property (@(posedge clk) disable iff (!rstN)
    (curL != $past(curL)) |->
      ((curL == $past(curL) + 6'd1) || (curL == $past(curL) - 6'd1)));

  p_unit_step_right_r4: assert property (@(posedge clk) disable iff (!rstN)
    (curR != $past(curR)) |->
      ((curR == $past(curR) + 6'd1) || (curR == $past(curR) - 6'd1)));

  p_silent_left_r2: assert property (@(posedge clk) disable iff (!rstN)
    (frameStrobe && curL == 6'd0) |=> (outL == '0));

  p_silent_right_r2: assert property (@(posedge clk) disable iff (!rstN)
    (frameStrobe && curR == 6'd0) |=> (outR == '0));

  p_single_channel_r8: assert property (@(posedge clk) disable iff (!rstN)
    (frameStrobe && zcEn) |=>
      !((curL != $past(curL)) && (curR != $past(curR))));
endmodule

bind soft_ramp_atten soft_ramp_atten_checker #(.DATA_W(DATA_W)) u_checker (
  .clk(clk), .rstN(rstN), .frameStrobe(frameStrobe), .zcEn(zcEn),
  .curL(dpCtrl.levelL), .curR(dpCtrl.levelR),
  .outL(outL), .outR(outR), .outValid(outValid)
);

// File: tb/soft_ramp_atten_tb.sv
`timescale 1ns/1ps
module soft_ramp_atten_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStrobe = 1'b0;
  logic signed [23:0] inL = '0, inR = '0;
  logic [5:0] levelL = 6'd63, levelR = 6'd63;
  logic muteL = 1'b0, muteR = 1'b0, zcEn = 1'b0, invRight = 1'b0;
  logic signed [23:0] outL, outR;
  logic outValid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference state
  int mCur [2];
  bit mArmed;
  int mTurn;
  int mWait;
  int mCnt;
  bit mPrev [2];

  always #4 clk = ~clk;

  soft_ramp_atten u_dut (
    .clk(clk), .rstN(rstN), .frameStrobe(frameStrobe), .inL(inL), .inR(inR),
    .levelL(levelL), .levelR(levelR), .muteL(muteL), .muteR(muteR),
    .zcEn(zcEn), .invRight(invRight), .outL(outL), .outR(outR),
    .outValid(outValid)
  );

  function automatic longint gainRef(int code);
    longint g = 64'sd8388608;
    if (code == 0) return 0;
    for (int c = 63; c > code; c--) g = (g * 64'sd956973408 + 64'sd536870912) >>> 30;
    return g;
  endfunction

  function automatic longint scaleRef(longint s, int code);
    longint r;
    r = (s * gainRef(code) + 64'sd4194304) >>> 23;
    if (r > 8388607) r = 8388607;
    if (r < -8388608) r = -8388608;
    return r;
  endfunction

  function automatic longint invRef(longint v);
    if (v == -8388608) return 8388607;
    return -v;
  endfunction

  function automatic int toward(int c, int t);
    if (c < t) return c + 1;
    if (c > t) return c - 1;
    return c;
  endfunction

  task automatic check(input bit ok, input string tag, input longint aL, input longint aR,
                       input longint eL, input longint eR);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual L=%0d R=%0d expected L=%0d R=%0d", tag, aL, aR, eL, eR);
    end
  endtask

  task automatic modelStep(input logic signed [23:0] l, input logic signed [23:0] r);
    int tg [2];
    bit zc [2];
    bit tick;
    tg[0] = muteL ? 0 : int'(levelL);
    tg[1] = muteR ? 0 : int'(levelR);
    zc[0] = (l[23] != mPrev[0]) || (l == 0);
    zc[1] = (r[23] != mPrev[1]) || (r == 0);
    tick = (mCnt == 7);
    if (!zcEn) begin
      mArmed = 0; mWait = 0;
      if (tick) for (int ch = 0; ch < 2; ch++) mCur[ch] = toward(mCur[ch], tg[ch]);
    end else if (mArmed) begin
      if (zc[mTurn] || mWait == 511) begin
        mCur[mTurn] = toward(mCur[mTurn], tg[mTurn]);
        mArmed = 0; mTurn = 1 - mTurn; mWait = 0;
      end else mWait++;
    end else if (tick) begin
      mWait = 0;
      if (mCur[mTurn] != tg[mTurn]) mArmed = 1;
      else if (mCur[1-mTurn] != tg[1-mTurn]) begin mArmed = 1; mTurn = 1 - mTurn; end
    end
    mCnt = (mCnt + 1) % 8;
    mPrev[0] = l[23];
    mPrev[1] = r[23];
  endtask

  task automatic doFrame(input logic signed [23:0] l, input logic signed [23:0] r,
                         input string tag);
    longint eL, eR;
    @(negedge clk);
    inL = l; inR = r; frameStrobe = 1'b1;
    eL = scaleRef(l, mCur[0]);
    eR = scaleRef(r, mCur[1]);
    if (invRight) eR = invRef(eR);
    @(negedge clk);
    frameStrobe = 1'b0;
    check(outValid === 1'b1 && longint'(outL) == eL && longint'(outR) == eR,
          tag, outL, outR, eL, eR);
    modelStep(l, r);
    @(negedge clk);
    // R10: outputs hold and valid drops between strobes
    check(outValid === 1'b0 && longint'(outL) == eL && longint'(outR) == eR,
          "R10 hold", outL, outR, eL, eR);
  endtask

  function automatic logic signed [23:0] rndSample();
    int k = $urandom_range(0, 15);
    if (k == 0) return 24'sd0;
    if (k == 1) return 24'sh800000;
    if (k == 2) return 24'sh7fffff;
    return 24'($urandom);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5eed);
    mCur[0] = 63; mCur[1] = 63; mArmed = 0; mTurn = 0; mWait = 0; mCnt = 0;
    mPrev[0] = 0; mPrev[1] = 0;

    repeat (3) @(negedge clk);
    check(outValid === 1'b0 && outL === 24'sd0 && outR === 24'sd0, "R1 reset",
          outL, outR, 0, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid === 1'b0 && outL === 24'sd0 && outR === 24'sd0, "R1 after release",
          outL, outR, 0, 0);

    // R1/R3: unity gain right after reset
    doFrame(24'sd1000, -24'sd1000, "R1 unity");
    doFrame(24'sh7fffff, 24'sh800000, "R3 full scale");
    for (int i = 0; i < 40; i++) doFrame(rndSample(), rndSample(), "R3 random unity");

    // R4: ramp both channels down in normal mode
    levelL = 6'd40; levelR = 6'd50;
    for (int i = 0; i < 220; i++) doFrame(rndSample(), rndSample(), "R4 ramp down");
    doFrame(24'sh400000, -24'sh400000, "R4 settled");
    check(mCur[0] == 40 && mCur[1] == 50, "R4 model settled", mCur[0], mCur[1], 40, 50);

    // R5 / R2: mute left ramps to silence, then back
    muteL = 1'b1;
    for (int i = 0; i < 340; i++) doFrame(rndSample(), rndSample(), "R5 mute ramp");
    doFrame(24'sh7fffff, 24'sh7fffff, "R2 level zero silent");
    muteL = 1'b0;
    for (int i = 0; i < 340; i++) doFrame(rndSample(), rndSample(), "R5 unmute ramp");

    // R9: inversion at unity with most negative sample
    levelR = 6'd63;
    for (int i = 0; i < 120; i++) doFrame(rndSample(), rndSample(), "R4 ramp up");
    invRight = 1'b1;
    doFrame(24'sd12345, 24'sh800000, "R9 invert saturate");
    doFrame(-24'sd77, 24'sh7fffff, "R9 invert max");
    for (int i = 0; i < 20; i++) doFrame(rndSample(), rndSample(), "R9 invert random");
    invRight = 1'b0;

    // R7: zero-cross mode with no crossings -> timeout
    zcEn = 1'b1;
    levelL = 6'd38; levelR = 6'd60;
    for (int i = 0; i < 1100; i++) doFrame(24'sd500000, 24'sd600000, "R7 timeout");

    // R6 / R8: alternating signs cross every frame
    for (int i = 0; i < 200; i++)
      doFrame((i % 2) ? 24'sd300000 : -24'sd300000,
              (i % 3) ? 24'sd200000 : -24'sd200000, "R6 R8 crossing");
    levelL = 6'd45; levelR = 6'd45;
    for (int i = 0; i < 200; i++) doFrame(24'sd0, 24'sd0, "R6 zero sample");

    // random mix of everything
    for (int i = 0; i < 1500; i++) begin
      if ($urandom_range(0, 63) == 0) levelL = 6'($urandom);
      if ($urandom_range(0, 63) == 0) levelR = 6'($urandom);
      if ($urandom_range(0, 127) == 0) muteL = ~muteL;
      if ($urandom_range(0, 127) == 0) muteR = ~muteR;
      if ($urandom_range(0, 255) == 0) zcEn = ~zcEn;
      if ($urandom_range(0, 127) == 0) invRight = ~invRight;
      doFrame(rndSample(), rndSample(), "R8 random mix");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule